// File: doc/BRIEF.md
# Multi-Queue Descriptor Fetch Scheduler

This block keeps the fetch state for a handful of descriptor rings (four by default). Software moves a ring's producer index forward; the block compares it with the index it last fetched up to. It reports the number of waiting descriptors per queue on a status vector and turns them into read requests. Each request carries a queue number, a start address and a descriptor count. A request is issued only when four gates all allow it: the queue's fetch credits (if crediting is switched on for that queue), the largest read a single request may ask for, free room in the shared completion buffer, and a rule that a queue may have only one fetch in flight.

Completion beats come back one descriptor per beat. They are steered by a per-queue mode bit, either to a bypass output for user logic or to an engine output. The buffer room a fetch reserved is handed back one entry per delivered descriptor. The top slot of every ring holds status and is never a descriptor slot, so ring indices count modulo ring size minus one. A producer index that points at or past that slot is refused.

Top module: `dfs_fetch_sched`

## Requirements
- R1: `avail_o[q]` equals (producer index − last fetched index) modulo (RING_SIZE − 1), is visible the cycle after the producer write, and never exceeds RING_SIZE − 2.
- R2: A producer write with a value above RING_SIZE − 2 leaves that queue's producer index unchanged and sets `pidx_err_o[q]`, which stays set until reset.
- R3: The request count is the smallest of: the available count, MRRS_BYTES / DESC_BYTES, the slots from the last fetched index up to the end of the ring, and the credit count when crediting is enabled.
- R4: The request address is `cfg_base_i[q]` + last fetched index × DESC_BYTES. At issue, the last fetched index advances by the count, modulo RING_SIZE − 1.
- R5: A queue with crediting enabled and zero credits issues nothing. Each issued descriptor uses one credit, and credit writes add to the count.
- R6: A fetch issues only if its count is at most the number of unreserved completion entries. Issue reserves the count, and each delivered descriptor frees one entry.
- R7: A queue issues no second request until a completion beat with `cpl_last_i` arrives for it.
- R8: While `req_valid_o` is high and `req_ready_i` is low, the request fields stay unchanged.
- R9: A completion beat appears one cycle later on the bypass port if `cfg_bypass_i[q]` is 1, or on the engine port if it is 0, never on both.
- R10: Among eligible queues, the grant goes to the first one at or after the queue following the last one granted.
- R11: After reset, no request is pending, all counts and error flags are zero, and both output ports are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_i | input | NQ×ADDR_W | Ring base address per queue |
| cfg_bypass_i | input | NQ | 1 = deliver to bypass port |
| cfg_credit_en_i | input | NQ | 1 = fetches limited by credits |
| pidx_we_i | input | 1 | Producer index write strobe |
| pidx_qid_i | input | QID_W | Queue of the producer write |
| pidx_val_i | input | IDX_W | New producer index |
| credit_we_i | input | 1 | Credit grant strobe |
| credit_qid_i | input | QID_W | Queue receiving credits |
| credit_amt_i | input | CREDIT_W | Credits added |
| avail_o | output | NQ×IDX_W | Waiting descriptor count per queue |
| pidx_err_o | output | NQ | Sticky out-of-range producer write flag |
| req_valid_o | output | 1 | Fetch request valid |
| req_ready_i | input | 1 | Fetch request accepted |
| req_qid_o | output | QID_W | Requesting queue |
| req_addr_o | output | ADDR_W | First descriptor address |
| req_cnt_o | output | IDX_W | Descriptors requested |
| cpl_valid_i | input | 1 | Completion beat valid (one descriptor) |
| cpl_qid_i | input | QID_W | Queue of the beat |
| cpl_last_i | input | 1 | Final beat of the fetch |
| cpl_data_i | input | DATA_W | Descriptor data |
| byp_valid_o | output | 1 | Bypass output valid |
| byp_qid_o | output | QID_W | Bypass output queue |
| byp_data_o | output | DATA_W | Bypass output descriptor |
| eng_valid_o | output | 1 | Engine output valid |
| eng_qid_o | output | QID_W | Engine output queue |
| eng_data_o | output | DATA_W | Engine output descriptor |

## Verification
A wrong last-fetched index shows up on the next request as a bad address and in `avail_o` in the same cycle as the issue. A wrong wrap modulus first appears when a ring crosses its reserved slot. A leak in completion-space accounting is quieter: it shows only as a request that fails to appear, possibly many fetches later, when the buffer is nearly full. For that reason the bench fills the buffer on purpose and watches the blocked queue start again within a beat of the release. A missing busy clear or a wrong credit count also shows as a missing or extra request within two cycles of the event that should change it.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    typedef enum logic {
        ROUTE_ENG = 1'b0,
        ROUTE_BYP = 1'b1
    } route_e;

    // Forward distance from l to p on a ring of m usable slots.
    function automatic logic [31:0] ring_dist(input logic [31:0] p, input logic [31:0] l,
                                              input logic [31:0] m);
        return (p >= l) ? (p - l) : (p + m - l);
    endfunction

    function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dfs_qctx.sv
module dfs_qctx #(
    parameter int RING_SIZE = 8,
    parameter int IDX_W     = 3,
    parameter int CREDIT_W  = 8,
    parameter int MAXN      = 4,
    parameter int FREE_W    = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pidx_we,
    input  logic [IDX_W-1:0]    pidx_val,
    input  logic                cred_we,
    input  logic [CREDIT_W-1:0] cred_amt,
    input  logic                cred_en,
    input  logic                issue,
    input  logic                cpl_done,
    input  logic [FREE_W-1:0]   free_ent,
    output logic [IDX_W-1:0]    avail,
    output logic [IDX_W-1:0]    fcnt,
    output logic [IDX_W-1:0]    lidx,
    output logic                elig,
    output logic                err
);
    import dfs_pkg::*;

    localparam int SLOTS = RING_SIZE - 1;
    localparam int CW1   = CREDIT_W + 1;

    logic [IDX_W-1:0]    pidx_q, lidx_q;
    logic [CREDIT_W-1:0] cred_q;
    logic                busy_q, err_q;
    logic [31:0]         lim;
    logic [IDX_W:0]      lsum;
    logic [CW1-1:0]      csum;

    assign avail = IDX_W'(ring_dist(32'(pidx_q), 32'(lidx_q), 32'(SLOTS)));
    assign lidx  = lidx_q;
    assign err   = err_q;

    always_comb begin
        lim = umin(32'(avail), 32'(MAXN));
        lim = umin(lim, 32'(SLOTS) - 32'(lidx_q));
        if (cred_en) lim = umin(lim, 32'(cred_q));
        fcnt = IDX_W'(lim);
    end

    assign elig = !busy_q && (fcnt != '0) && (32'(fcnt) <= 32'(free_ent));

    always_comb begin
        lsum = {1'b0, lidx_q} + {1'b0, fcnt};
        if (lsum >= (IDX_W+1)'(SLOTS)) lsum = lsum - (IDX_W+1)'(SLOTS);
        csum = {1'b0, cred_q};
        if (issue && cred_en) csum = csum - CW1'(fcnt);
        if (cred_we) csum = csum + {1'b0, cred_amt};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pidx_q <= '0;
            lidx_q <= '0;
            cred_q <= '0;
            busy_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (pidx_we) begin
                if (pidx_val <= IDX_W'(RING_SIZE - 2)) pidx_q <= pidx_val;
                else                                    err_q  <= 1'b1;
            end
            if (issue) begin
                lidx_q <= lsum[IDX_W-1:0];
                busy_q <= 1'b1;
            end else if (cpl_done) begin
                busy_q <= 1'b0;
            end
            cred_q <= csum[CREDIT_W] ? '1 : csum[CREDIT_W-1:0];
        end
    end
endmodule

// File: rtl/dfs_rr_arb.sv
module dfs_rr_arb #(
    parameter int N     = 4,
    parameter int QID_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             take,
    output logic             gnt_vld,
    output logic [QID_W-1:0] gnt_id
);
    logic [QID_W-1:0] ptr_q;

    always_comb begin
        int unsigned c;
        gnt_vld = 1'b0;
        gnt_id  = '0;
        for (int k = 0; k < N; k++) begin
            c = (32'(ptr_q) + 32'(k)) % N;
            if (!gnt_vld && req[c]) begin
                gnt_vld = 1'b1;
                gnt_id  = QID_W'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (take)
            ptr_q <= (32'(gnt_id) == N - 1) ? '0 : gnt_id + 1'b1;
    end
endmodule

// File: rtl/dfs_cpl_route.sv
module dfs_cpl_route #(
    parameter int NQ     = 4,
    parameter int QID_W  = 2,
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [QID_W-1:0]  in_qid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [NQ-1:0]     mode_byp,
    output logic              byp_valid,
    output logic              eng_valid,
    output logic [QID_W-1:0]  out_qid,
    output logic [DATA_W-1:0] out_data,
    output logic              deliver
);
    import dfs_pkg::*;

    logic   vld_q;
    route_e dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q    <= 1'b0;
            dst_q    <= ROUTE_ENG;
            out_qid  <= '0;
            out_data <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                dst_q    <= mode_byp[in_qid] ? ROUTE_BYP : ROUTE_ENG;
                out_qid  <= in_qid;
                out_data <= in_data;
            end
        end
    end

    assign byp_valid = vld_q && (dst_q == ROUTE_BYP);
    assign eng_valid = vld_q && (dst_q == ROUTE_ENG);
    assign deliver   = vld_q;
endmodule

// File: rtl/dfs_fetch_sched.sv
module dfs_fetch_sched #(
    parameter int NQ         = 4,
    parameter int RING_SIZE  = 8,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 256,
    parameter int DESC_BYTES = 32,
    parameter int MRRS_BYTES = 128,
    parameter int CBUF_DEPTH = 256,
    parameter int CREDIT_W   = 8,
    localparam int QID_W     = $clog2(NQ),
    localparam int IDX_W     = $clog2(RING_SIZE)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NQ-1:0][ADDR_W-1:0]    cfg_base_i,
    input  logic [NQ-1:0]                cfg_bypass_i,
    input  logic [NQ-1:0]                cfg_credit_en_i,
    input  logic                         pidx_we_i,
    input  logic [QID_W-1:0]             pidx_qid_i,
    input  logic [IDX_W-1:0]             pidx_val_i,
    input  logic                         credit_we_i,
    input  logic [QID_W-1:0]             credit_qid_i,
    input  logic [CREDIT_W-1:0]          credit_amt_i,
    output logic [NQ-1:0][IDX_W-1:0]     avail_o,
    output logic [NQ-1:0]                pidx_err_o,
    output logic                         req_valid_o,
    input  logic                         req_ready_i,
    output logic [QID_W-1:0]             req_qid_o,
    output logic [ADDR_W-1:0]            req_addr_o,
    output logic [IDX_W-1:0]             req_cnt_o,
    input  logic                         cpl_valid_i,
    input  logic [QID_W-1:0]             cpl_qid_i,
    input  logic                         cpl_last_i,
    input  logic [DATA_W-1:0]            cpl_data_i,
    output logic                         byp_valid_o,
    output logic [QID_W-1:0]             byp_qid_o,
    output logic [DATA_W-1:0]            byp_data_o,
    output logic                         eng_valid_o,
    output logic [QID_W-1:0]             eng_qid_o,
    output logic [DATA_W-1:0]            eng_data_o
);
    localparam int MAXN   = MRRS_BYTES / DESC_BYTES;
    localparam int FREE_W = $clog2(CBUF_DEPTH + 1);
    localparam int OFF_SH = $clog2(DESC_BYTES);

    logic [NQ-1:0][IDX_W-1:0] fcnt_a, lidx_a;
    logic [NQ-1:0]            elig_a;
    logic [FREE_W-1:0]        free_q;
    logic                     gnt_vld, issue_fire, deliver;
    logic [QID_W-1:0]         gnt_id, out_qid;
    logic [DATA_W-1:0]        out_data;

    assign issue_fire = gnt_vld && !req_valid_o;

    for (genvar q = 0; q < NQ; q++) begin : g_q
        dfs_qctx #(
            .RING_SIZE(RING_SIZE), .IDX_W(IDX_W), .CREDIT_W(CREDIT_W),
            .MAXN(MAXN), .FREE_W(FREE_W)
        ) u_ctx (
            .clk      (clk),
            .rst      (rst),
            .pidx_we  (pidx_we_i && (pidx_qid_i == QID_W'(q))),
            .pidx_val (pidx_val_i),
            .cred_we  (credit_we_i && (credit_qid_i == QID_W'(q))),
            .cred_amt (credit_amt_i),
            .cred_en  (cfg_credit_en_i[q]),
            .issue    (issue_fire && (gnt_id == QID_W'(q))),
            .cpl_done (cpl_valid_i && cpl_last_i && (cpl_qid_i == QID_W'(q))),
            .free_ent (free_q),
            .avail    (avail_o[q]),
            .fcnt     (fcnt_a[q]),
            .lidx     (lidx_a[q]),
            .elig     (elig_a[q]),
            .err      (pidx_err_o[q])
        );
    end

    dfs_rr_arb #(.N(NQ), .QID_W(QID_W)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (elig_a & {NQ{!req_valid_o}}),
        .take    (issue_fire),
        .gnt_vld (gnt_vld),
        .gnt_id  (gnt_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid_o <= 1'b0;
            req_qid_o   <= '0;
            req_addr_o  <= '0;
            req_cnt_o   <= '0;
        end else if (issue_fire) begin
            req_valid_o <= 1'b1;
            req_qid_o   <= gnt_id;
            req_addr_o  <= cfg_base_i[gnt_id] + (ADDR_W'(lidx_a[gnt_id]) << OFF_SH);
            req_cnt_o   <= fcnt_a[gnt_id];
        end else if (req_ready_i) begin
            req_valid_o <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            free_q <= FREE_W'(CBUF_DEPTH);
        else
            free_q <= free_q - (issue_fire ? FREE_W'(fcnt_a[gnt_id]) : '0)
                             + (deliver ? FREE_W'(1) : '0);
    end

    dfs_cpl_route #(.NQ(NQ), .QID_W(QID_W), .DATA_W(DATA_W)) u_route (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (cpl_valid_i),
        .in_qid    (cpl_qid_i),
        .in_data   (cpl_data_i),
        .mode_byp  (cfg_bypass_i),
        .byp_valid (byp_valid_o),
        .eng_valid (eng_valid_o),
        .out_qid   (out_qid),
        .out_data  (out_data),
        .deliver   (deliver)
    );

    assign byp_qid_o  = out_qid;
    assign eng_qid_o  = out_qid;
    assign byp_data_o = out_data;
    assign eng_data_o = out_data;
endmodule

// File: rtl/dfs_fetch_sched_chk.sv
module dfs_fetch_sched_chk #(
    parameter int NQ         = 4,
    parameter int RING_SIZE  = 8,
    parameter int QID_W      = 2,
    parameter int IDX_W      = 3,
    parameter int ADDR_W     = 32,
    parameter int MAXN       = 4,
    parameter int CBUF_DEPTH = 256,
    parameter int FREE_W     = 9
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_ready,
    input logic [QID_W-1:0]         req_qid,
    input logic [ADDR_W-1:0]        req_addr,
    input logic [IDX_W-1:0]         req_cnt,
    input logic [NQ-1:0][IDX_W-1:0] avail,
    input logic [NQ-1:0]            pidx_err,
    input logic                     cpl_valid,
    input logic                     byp_valid,
    input logic                     eng_valid,
    input logic [FREE_W-1:0]        free
);
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_qid)
                                       && $stable(req_addr) && $stable(req_cnt)));

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_cnt != '0) && (32'(req_cnt) <= MAXN)));

    assert_one_port_R9: assert property (@(posedge clk) disable iff (rst)
        !(byp_valid && eng_valid));

    assert_route_latency_R9: assert property (@(posedge clk) disable iff (rst)
        (byp_valid || eng_valid) |-> $past(cpl_valid));

    assert_err_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        ((pidx_err & $past(pidx_err)) == $past(pidx_err)));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        32'(free) <= CBUF_DEPTH);

    for (genvar q = 0; q < NQ; q++) begin : g_av
        assert_avail_max_R1: assert property (@(posedge clk) disable iff (rst)
            32'(avail[q]) <= RING_SIZE - 2);
    end
endmodule

bind dfs_fetch_sched dfs_fetch_sched_chk #(
    .NQ(NQ), .RING_SIZE(RING_SIZE), .QID_W(QID_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .MAXN(MAXN), .CBUF_DEPTH(CBUF_DEPTH), .FREE_W(FREE_W)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid_o), .req_ready(req_ready_i),
    .req_qid(req_qid_o), .req_addr(req_addr_o), .req_cnt(req_cnt_o),
    .avail(avail_o), .pidx_err(pidx_err_o), .cpl_valid(cpl_valid_i),
    .byp_valid(byp_valid_o), .eng_valid(eng_valid_o), .free(free_q)
);

// File: tb/dfs_fetch_sched_tb.sv
`timescale 1ns/1ps
module dfs_fetch_sched_tb;
    localparam int NQ = 4, RING = 8, AW = 32, DW = 256, CW = 8, QW = 2, IW = 3;
    localparam logic [NQ-1:0] BYP = 4'b0101;
    localparam logic [NQ-1:0] CEN = 4'b0010;
    // {pidx, expected avail, expected sticky error} for queue 1 (credited, no credits)
    localparam logic [6:0] TBL [0:4] = '{
        {3'd3, 3'd3, 1'b0}, {3'd6, 3'd6, 1'b0}, {3'd7, 3'd6, 1'b1},
        {3'd0, 3'd0, 1'b1}, {3'd2, 3'd2, 1'b1}};

    logic clk = 1'b0, rst = 1'b1;
    logic [NQ-1:0][AW-1:0] cfg_base;
    logic pidx_we = 0, credit_we = 0, req_ready = 0, cpl_valid = 0, cpl_last = 0;
    logic [QW-1:0] pidx_qid = 0, credit_qid = 0, cpl_qid = 0;
    logic [IW-1:0] pidx_val = 0;
    logic [CW-1:0] credit_amt = 0;
    logic [DW-1:0] cpl_data = '0;
    logic [NQ-1:0][IW-1:0] avail;
    logic [NQ-1:0] perr;
    logic req_valid, byp_valid, eng_valid;
    logic [QW-1:0] req_qid, byp_qid, eng_qid;
    logic [AW-1:0] req_addr;
    logic [IW-1:0] req_cnt;
    logic [DW-1:0] byp_data, eng_data;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    dfs_fetch_sched #(.CBUF_DEPTH(6)) u_dut (
        .clk(clk), .rst(rst), .cfg_base_i(cfg_base), .cfg_bypass_i(BYP),
        .cfg_credit_en_i(CEN), .pidx_we_i(pidx_we), .pidx_qid_i(pidx_qid),
        .pidx_val_i(pidx_val), .credit_we_i(credit_we), .credit_qid_i(credit_qid),
        .credit_amt_i(credit_amt), .avail_o(avail), .pidx_err_o(perr),
        .req_valid_o(req_valid), .req_ready_i(req_ready), .req_qid_o(req_qid),
        .req_addr_o(req_addr), .req_cnt_o(req_cnt), .cpl_valid_i(cpl_valid),
        .cpl_qid_i(cpl_qid), .cpl_last_i(cpl_last), .cpl_data_i(cpl_data),
        .byp_valid_o(byp_valid), .byp_qid_o(byp_qid), .byp_data_o(byp_data),
        .eng_valid_o(eng_valid), .eng_qid_o(eng_qid), .eng_data_o(eng_data));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_pidx(input int q, input int v);
        pidx_we = 1; pidx_qid = QW'(q); pidx_val = IW'(v);
        @(negedge clk); pidx_we = 0;
    endtask

    task automatic give_credit(input int q, input int n);
        credit_we = 1; credit_qid = QW'(q); credit_amt = CW'(n);
        @(negedge clk); credit_we = 0;
    endtask

    task automatic accept();
        req_ready = 1; @(negedge clk); req_ready = 0;
    endtask

    task automatic exp_req(input string tag, input int q, input int addr, input int cnt);
        chk({tag, " req_valid"}, 64'(req_valid), 64'd1);
        chk({tag, " req_qid"}, 64'(req_qid), 64'(q));
        chk({tag, " req_addr"}, 64'(req_addr), 64'(addr));
        chk({tag, " req_cnt"}, 64'(req_cnt), 64'(cnt));
    endtask

    task automatic cpl(input int q, input int n, input int base);
        for (int i = 0; i < n; i++) begin
            cpl_valid = 1; cpl_qid = QW'(q); cpl_last = (i == n - 1);
            cpl_data = DW'(base + i);
            @(negedge clk);
            chk("R9 byp_valid", 64'(byp_valid), 64'(BYP[q]));
            chk("R9 eng_valid", 64'(eng_valid), 64'(!BYP[q]));
            chk("R9 data", BYP[q] ? byp_data[63:0] : eng_data[63:0], 64'(base + i));
            chk("R9 qid", 64'(BYP[q] ? byp_qid : eng_qid), 64'(q));
        end
        cpl_valid = 0; cpl_last = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int q = 0; q < NQ; q++) cfg_base[q] = AW'(32'h1000 * (q + 1));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk("R11 req_valid", 64'(req_valid), 0);
        chk("R11 avail", 64'(avail), 0);
        chk("R11 err", 64'(perr), 0);
        chk("R11 outputs", 64'({byp_valid, eng_valid}), 0);

        // R1 / R2 / R5: table walk on queue 1 which has crediting on and zero credits
        for (int i = 0; i < 5; i++) begin
            wr_pidx(1, int'(TBL[i][6:4]));
            chk("R1 avail q1", 64'(avail[1]), 64'(TBL[i][3:1]));
            chk("R2 sticky err q1", 64'(perr[1]), 64'(TBL[i][0]));
            @(negedge clk);
            chk("R5 no credit no request", 64'(req_valid), 0);
        end

        // R3 size limit, R4 address, R8 hold, R7 single outstanding
        wr_pidx(0, 6);
        chk("R1 avail q0", 64'(avail[0]), 6);
        @(negedge clk);
        exp_req("R3 mrrs limit", 0, 'h1000, 4);
        chk("R4 avail after issue", 64'(avail[0]), 2);
        repeat (3) @(negedge clk);
        exp_req("R8 held", 0, 'h1000, 4);
        accept();
        @(negedge clk);
        chk("R7 busy queue idle", 64'(req_valid), 0);
        cpl(0, 4, 'h10);
        @(negedge clk);
        exp_req("R7 reissue after last", 0, 'h1080, 2);
        chk("R9 outputs idle", 64'({byp_valid, eng_valid}), 0);
        accept();
        cpl(0, 2, 'h20);

        // R4 wrap across reserved slot, R3 end-of-ring limit
        wr_pidx(0, 3);
        chk("R1 wrap avail", 64'(avail[0]), 4);
        @(negedge clk);
        exp_req("R3 ring end limit", 0, 'h10C0, 1);
        chk("R4 avail", 64'(avail[0]), 3);
        accept();
        cpl(0, 1, 'h30);
        @(negedge clk);
        exp_req("R4 wrapped index", 0, 'h1000, 3);
        accept();
        cpl(0, 3, 'h40);

        // R5 credits limit the count and are consumed
        give_credit(1, 1);
        @(negedge clk);
        exp_req("R5 credit limit", 1, 'h2000, 1);
        chk("R5 avail q1", 64'(avail[1]), 1);
        accept();
        cpl(1, 1, 'h50);
        repeat (3) @(negedge clk);
        chk("R5 credits used up", 64'(req_valid), 0);

        // R6 completion space gate
        wr_pidx(0, 0);
        chk("R1 avail q0", 64'(avail[0]), 4);
        @(negedge clk);
        exp_req("R6 fits", 0, 'h1060, 4);
        accept();
        wr_pidx(2, 4);
        repeat (4) @(negedge clk);
        chk("R6 blocked by space", 64'(req_valid), 0);
        chk("R6 q2 still waiting", 64'(avail[2]), 4);
        cpl(0, 4, 'h60);
        @(negedge clk);
        exp_req("R6 released", 2, 'h3000, 4);

        // R10 round robin starts after last grant (q2), so q3 beats q0
        wr_pidx(0, 1);
        wr_pidx(3, 2);
        accept();
        @(negedge clk);
        exp_req("R10 rr order", 3, 'h4000, 2);
        accept();
        cpl(2, 4, 'h70);
        exp_req("R10 then q0", 0, 'h1000, 1);
        accept();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule